// File: doc/BRIEF.md
# Pin-Interrupt GPIO Port

This block is one memory-mapped bank of general-purpose pins, 32 wide by default. Software drives pins through an output-value register and an output-enable register. It samples them through a read-only input register that follows a two-flop synchroniser. Each pin can also act as an interrupt source.

Each pin's trigger is chosen by two control bits: a mode bit (level or edge) and a polarity bit (high/rising or low/falling). A pin can raise a sticky status bit only when its routing bit is set. Every status bit that is pending and enabled feeds one shared interrupt line.

Each writable register can be written in full, or changed through a set alias and a clear alias that touch only the bits written as 1. Status can be cleared only through its clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is low.
- R2: The word address is split into two fields. Bits [4:2] give the register index: 0 output value, 1 input (read-only), 2 output enable, 3 interrupt routing, 4 interrupt enable, 5 mode (1 = level, 0 = edge), 6 polarity (1 = high/rising, 0 = low/falling), 7 status. Bits [1:0] give the access kind: 0 full write, 1 set, 2 clear, 3 no effect. A read returns the register value whatever the access kind.
- R3: A set access ORs the write data into the register. A clear access removes the bits written as 1. All other bits keep their value.
- R4: `pin_out` always equals the output value register, and `pin_oe` always equals the output enable register.
- R5: Writes to the input register have no effect. Its value equals `pin_in` as it was two rising clock edges earlier.
- R6: Full writes and set writes to the status register have no effect. Only a clear access removes status bits.
- R7: A pin whose routing bit is 0 never sets its status bit.
- R8: In edge mode a pin sets its status bit on the third rising clock edge after its input moves toward the polarity value. A move the other way sets nothing.
- R9: In level mode the status bit is set on every clock while the synchronised input equals the polarity value. A clear access has no effect until the level goes away.
- R10: A status bit stays set after its cause is gone, until it is cleared.
- R11: `irq` is high exactly when some bit is set in both the status register and the enable register.
- R12: When a trigger and a clear access hit the same status bit in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Word address: register index and access kind |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Per-pin output drive enable |
| irq | output | 1 | Port interrupt |

## Verification
A wrong register bit shows up on the next read of that register, or at once on `pin_out`/`pin_oe`. A fault in trigger decoding appears as a status bit that is missing, or set a clock early or late, against the three-edge edge latency and the one-cycle level latency. A lost or stuck status bit is also visible on `irq` in the cycle after it occurs. Randomised access kinds on the control registers catch merge errors in the set and clear paths, and directed sequences cover sticky status, clear-while-active and enable masking.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int MAX_PINS = 32;
   localparam int IDX_W    = 3;
   localparam int KIND_W   = 2;
   localparam int ADDR_W   = IDX_W + KIND_W;
   localparam int NUM_REGS = 1 << IDX_W;

   typedef enum logic [IDX_W-1:0] {
      RG_DOUT = 3'd0,
      RG_DIN  = 3'd1,
      RG_OE   = 3'd2,
      RG_SEL  = 3'd3,
      RG_EN   = 3'd4,
      RG_LEV  = 3'd5,
      RG_POL  = 3'd6,
      RG_STAT = 3'd7
   } reg_idx_e;

   typedef enum logic [KIND_W-1:0] {
      AK_WRITE = 2'd0,
      AK_SET   = 2'd1,
      AK_CLR   = 2'd2,
      AK_NONE  = 2'd3
   } acc_kind_e;

   // Merge write data into a register value according to the access kind.
   function automatic logic [MAX_PINS-1:0] merge_word(
      input logic [MAX_PINS-1:0] cur,
      input logic [MAX_PINS-1:0] wd,
      input acc_kind_e           kind);
      case (kind)
         AK_WRITE: merge_word = wd;
         AK_SET:   merge_word = cur | wd;
         AK_CLR:   merge_word = cur & ~wd;
         default:  merge_word = cur;
      endcase
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

   // R5: last stage follows the stage before it one clock later
   assert_sync_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q == $past(chain[STAGES-2]));
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] sel,
   input  logic [W-1:0] lev,
   input  logic [W-1:0] pol,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   for (genvar p = 0; p < W; p++) begin : g_pin
      logic at_pol, moved;
      assign at_pol = (smp[p] == pol[p]);
      assign moved  = (smp[p] != prev[p]);
      assign evt[p] = sel[p] & at_pol & (lev[p] | moved);
   end
endmodule

// File: rtl/gpio_stat.sv
module gpio_stat #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] clr_mask,
   input  logic [W-1:0] en,
   output logic [W-1:0] stat,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr_mask) | evt;
   end

   assign irq = |(stat & en);

   // R6: a status bit falls only where a clear was requested
   assert_stat_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~stat & $past(stat) & ~$past(clr_mask)) == '0));

   // R12: a trigger always leaves its bit set, clear or not
   assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat & $past(evt)) == $past(evt)));

   // R11: interrupt only rises when status or enable changed
   assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (stat != $past(stat)) || (en != $past(en)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_port_pkg::*;
#(
   parameter int NPINS  = 32,
   parameter int SYNC_N = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [MAX_PINS-1:0]  bus_wdata,
   output logic [MAX_PINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]     pin_in,
   output logic [NPINS-1:0]     pin_out,
   output logic [NPINS-1:0]     pin_oe,
   output logic                 irq
);
   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_npins
      $error("gpio_irq_port: NPINS out of range");
   end

   reg_idx_e           idx;
   acc_kind_e          kind;
   logic [NPINS-1:0]   wd;
   logic [NPINS-1:0]   view [NUM_REGS];
   logic [NPINS-1:0]   din, evt, stat, clr_mask;

   assign idx  = reg_idx_e'(bus_addr[ADDR_W-1:KIND_W]);
   assign kind = acc_kind_e'(bus_addr[KIND_W-1:0]);
   assign wd   = bus_wdata[NPINS-1:0];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == int'(RG_DIN)) begin : g_in
         assign view[i] = din;
      end else if (i == int'(RG_STAT)) begin : g_st
         assign view[i] = stat;
      end else begin : g_rw
         logic [NPINS-1:0] q;
         logic [MAX_PINS-1:0] cur_w, nxt_w;
         assign cur_w = MAX_PINS'(q);
         assign nxt_w = merge_word(cur_w, MAX_PINS'(wd), kind);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (bus_we && idx == reg_idx_e'(i)) q <= nxt_w[NPINS-1:0];
         end
         assign view[i] = q;
      end
   end

   assign clr_mask  = (bus_we && idx == RG_STAT && kind == AK_CLR) ? wd : '0;
   assign bus_rdata = MAX_PINS'(view[idx]);
   assign pin_out   = view[RG_DOUT];
   assign pin_oe    = view[RG_OE];

   gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din));

   gpio_trig #(.W(NPINS)) u_trig (
      .clk(clk), .rst_n(rst_n), .smp(din),
      .sel(view[RG_SEL]), .lev(view[RG_LEV]), .pol(view[RG_POL]),
      .evt(evt));

   gpio_stat #(.W(NPINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr_mask(clr_mask),
      .en(view[RG_EN]), .stat(stat), .irq(irq));

   // R3: set access on the output value register ORs in the data
   assert_set_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && idx == RG_DOUT && kind == AK_SET) |=>
         pin_out == ($past(pin_out) | $past(wd)));

   // R7: no status bit rises on a pin that was not routed
   assert_route_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat & ~$past(stat) & ~$past(view[RG_SEL])) == '0));
endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   localparam logic [2:0] I_DOUT = 0, I_DIN = 1, I_OE = 2, I_SEL = 3,
                          I_EN = 4, I_LEV = 5, I_POL = 6, I_STAT = 7;
   localparam logic [1:0] K_WR = 0, K_SET = 1, K_CLR = 2, K_NONE = 3;

   function automatic logic [4:0] adr(input logic [2:0] i, input logic [1:0] k);
      return {i, k};
   endfunction

   function automatic logic [31:0] model(input logic [31:0] cur, input logic [31:0] d,
                                         input logic [1:0] k);
      if (k == K_WR)  return d;
      if (k == K_SET) return cur | d;
      if (k == K_CLR) return cur & ~d;
      return cur;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] i, input logic [1:0] k, input logic [31:0] d);
      @(negedge clk);
      bus_addr = adr(i, k); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] i, input logic [1:0] k, output logic [31:0] d);
      @(negedge clk);
      bus_addr = adr(i, k);
      #1 d = bus_rdata;
   endtask

   task automatic pins(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] m [8];
      void'($urandom(32'd5150));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 8; i++) begin
         rd(3'(i), K_WR, v);
         chk("R1 reg reset", v, 32'h0);
      end
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_oe", pin_oe, 0);
      chk("R1 irq", {31'b0, irq}, 0);

      // R5: input register latency and read-only
      pins(32'hA5A5_3C00);
      edges(1);
      rd(I_DIN, K_WR, v);
      chk("R5 din after one edge", v, 32'h0);
      edges(1);
      rd(I_DIN, K_SET, v);
      chk("R5 din after two edges", v, 32'hA5A5_3C00);
      wr(I_DIN, K_WR, 32'hFFFF_FFFF);
      rd(I_DIN, K_WR, v);
      chk("R5 din write ignored", v, 32'hA5A5_3C00);
      pins(32'h0);
      edges(4);

      // R3/R4: directed set/clear on output value
      wr(I_DOUT, K_WR, 32'hF0F0_1234);
      wr(I_DOUT, K_SET, 32'h0000_000F);
      chk("R3 set alias", pin_out, 32'hF0F0_123F);
      wr(I_DOUT, K_CLR, 32'hF000_0000);
      chk("R3 clear alias", pin_out, 32'h00F0_123F);
      wr(I_DOUT, K_NONE, 32'hFFFF_FFFF);
      chk("R2 kind 3 no effect", pin_out, 32'h00F0_123F);
      wr(I_OE, K_WR, 32'h1234_5678);
      chk("R4 pin_oe", pin_oe, 32'h1234_5678);

      // R2/R3/R4: random accesses on the writable control registers
      for (int i = 0; i < 8; i++) m[i] = '0;
      m[I_DOUT] = 32'h00F0_123F;
      m[I_OE]   = 32'h1234_5678;
      for (int n = 0; n < 300; n++) begin
         logic [2:0] ri;
         logic [1:0] rk;
         logic [31:0] rdv;
         case ($urandom % 6)
            0: ri = I_DOUT; 1: ri = I_OE; 2: ri = I_SEL;
            3: ri = I_EN;   4: ri = I_LEV; default: ri = I_POL;
         endcase
         rk  = 2'($urandom % 4);
         rdv = $urandom;
         m[ri] = model(m[ri], rdv, rk);
         wr(ri, rk, rdv);
         rd(ri, 2'($urandom % 4), v);
         chk("R2 R3 random readback", v, m[ri]);
      end
      chk("R4 pin_out random", pin_out, m[I_DOUT]);
      chk("R4 pin_oe random", pin_oe, m[I_OE]);

      // back to a quiet state
      wr(I_SEL, K_WR, 0); wr(I_LEV, K_WR, 0); wr(I_POL, K_WR, 0);
      wr(I_EN, K_WR, 0);
      wr(I_STAT, K_CLR, 32'hFFFF_FFFF);
      rd(I_STAT, K_WR, v);
      chk("R6 status cleared", v, 0);

      // R7: unrouted pin cannot set status
      wr(I_POL, K_SET, 32'h1);
      wr(I_EN, K_WR, 32'h1);
      pins(32'h1); edges(4);
      rd(I_STAT, K_WR, v);
      chk("R7 unrouted rise", v, 0);
      pins(32'h0); edges(4);

      // R8: rising edge on pin 0
      wr(I_SEL, K_WR, 32'hFFFF_FFFF);
      pins(32'h1);
      edges(2);
      rd(I_STAT, K_WR, v);
      chk("R8 not yet at second edge", v, 0);
      edges(1);
      rd(I_STAT, K_WR, v);
      chk("R8 rising sets at third edge", v, 32'h1);
      chk("R11 irq with enabled status", {31'b0, irq}, 1);
      pins(32'h0); edges(4);
      rd(I_STAT, K_WR, v);
      chk("R10 sticky after fall", v, 32'h1);
      wr(I_STAT, K_WR, 32'h0);
      wr(I_STAT, K_SET, 32'hFFFF);
      rd(I_STAT, K_WR, v);
      chk("R6 write and set ignored", v, 32'h1);
      wr(I_STAT, K_CLR, 32'h1);
      rd(I_STAT, K_WR, v);
      chk("R6 clear alias", v, 0);
      chk("R11 irq low after clear", {31'b0, irq}, 0);

      // R8: falling edge on pin 1
      pins(32'h2); edges(4);
      rd(I_STAT, K_WR, v);
      chk("R8 wrong direction ignored", v, 0);
      pins(32'h0); edges(3);
      rd(I_STAT, K_WR, v);
      chk("R8 falling sets", v, 32'h2);
      chk("R11 masked by enable", {31'b0, irq}, 0);
      wr(I_EN, K_SET, 32'h2);
      chk("R11 irq after enable", {31'b0, irq}, 1);
      wr(I_STAT, K_CLR, 32'h2);
      chk("R11 irq after clear", {31'b0, irq}, 0);

      // R9/R12: level high on pin 2
      wr(I_LEV, K_SET, 32'h4);
      wr(I_POL, K_SET, 32'h4);
      pins(32'h4); edges(3);
      rd(I_STAT, K_WR, v);
      chk("R9 level high sets", v, 32'h4);
      wr(I_STAT, K_CLR, 32'h4);
      rd(I_STAT, K_WR, v);
      chk("R12 clear loses to active level", v, 32'h4);
      pins(32'h0); edges(3);
      wr(I_STAT, K_CLR, 32'h4);
      rd(I_STAT, K_WR, v);
      chk("R9 clear after level gone", v, 0);

      // R9: level low on pin 3
      wr(I_LEV, K_SET, 32'h8);
      edges(1);
      rd(I_STAT, K_WR, v);
      chk("R9 level low sets", v, 32'h8);
      pins(32'h8); edges(3);
      wr(I_STAT, K_CLR, 32'h8);
      edges(3);
      rd(I_STAT, K_WR, v);
      chk("R9 stays clear when inactive", v, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule